// File: doc/BRIEF.md
# Configurable Input Macrocell Array

This block sits between twenty port pins and a programmable logic array. Each pin feeds one input cell. A cell either passes the pin straight through, acts as a level-sensitive latch, or acts as an edge-capturing register. The pins are grouped as two 8-bit ports (A and B) and one 4-bit port (C). The cell values drive the logic-array input bus. The CPU can also read them one port at a time over an 8-bit data bus.

Capture control is shared in nibbles: every group of four consecutive cells has a single control. That control is either the group's own product-term input or the common address-latch-enable strobe, chosen per group. A per-cell mode register and a per-group source bit hold the configuration. Register-mode capture is modelled synchronously, as a rising edge of the selected control sampled by the system clock.

Top module: `pin_capture_array`

## Requirements
- R1: After reset every cell is in pass-through mode, every group selects its product term, and every held cell value is 0.
- R2: A cell in mode 00 (and in the unused code 11) drives its pin value onto its output in the same cycle, with no clock edge needed.
- R3: A cell in mode 01 (latch) follows its pin while its group control is high. While the control is low, it shows the pin value sampled at the last clock edge at which the control was high.
- R4: A cell in mode 10 (register) stores its pin at a clock edge where its group control is high and was low at the previous edge. Its output changes only after such an edge.
- R5: Cells are numbered A0..A7 = 0..7, B0..B7 = 8..15, C0..C3 = 16..19. Group g covers cells 4g..4g+3 and uses product term pt_term[g], so the two nibbles of a port are controlled independently.
- R6: Source bit 0 selects the group's product term and source bit 1 selects addr_strobe. The control input that is not selected has no effect on that group.
- R7: A mode write (mode_we with mode_idx, mode_val) takes effect at the next clock edge. An index of 20 or more changes no cell. A source write (src_we with src_grp, src_val) works in the same way for groups 0..4.
- R8: rd_sel 00 returns port A cells, 01 port B cells, 10 port C cells in bits 3..0 with bits 7..4 zero, and 11 returns zero.
- R9: cell_bus bit n carries the output of cell n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 8 | Port A pins |
| pin_b | input | 8 | Port B pins |
| pin_c | input | 4 | Port C pins |
| pt_term | input | 5 | Product-term control, one per group |
| addr_strobe | input | 1 | Shared address-latch-enable strobe |
| mode_we | input | 1 | Cell mode write enable |
| mode_idx | input | 5 | Cell index for the mode write |
| mode_val | input | 2 | Mode code: 00 pass, 01 latch, 10 register |
| src_we | input | 1 | Group source write enable |
| src_grp | input | 3 | Group index for the source write |
| src_val | input | 1 | 0 product term, 1 strobe |
| cell_bus | output | 20 | Cell outputs to the logic array |
| rd_sel | input | 2 | Port select for CPU read |
| rd_data | output | 8 | CPU read data |

## Verification
The hardest case to observe is a register-mode cell that must not capture. Its pin changes while the selected control stays high, or while the unselected control toggles. The output then looks the same as if nothing happened, unless the pin value differs from the stored one. The stimulus therefore first captures a known nibble on a strobe rise and then changes the pin with the strobe still high. It then pulses the unselected product term and finally re-raises the strobe. Each step is read back over the data port, with a distinct value expected at each step.

// File: rtl/imc_pkg.sv
package imc_pkg;
    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_LATCH = 2'b01,
        MODE_REG   = 2'b10,
        MODE_RSVD  = 2'b11
    } cell_mode_e;
endpackage

// File: rtl/imc_cfg.sv
module imc_cfg
    import imc_pkg::*;
#(
    parameter int NCELL  = 20,
    parameter int NGRP   = 5,
    parameter int IDX_W  = 5,
    parameter int GIDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_we,
    input  logic [IDX_W-1:0]         mode_idx,
    input  cell_mode_e               mode_val,
    input  logic                     src_we,
    input  logic [GIDX_W-1:0]        src_grp,
    input  logic                     src_val,
    output cell_mode_e [NCELL-1:0]   mode_o,
    output logic [NGRP-1:0]          src_o
);
    typedef struct packed {
        cell_mode_e [NCELL-1:0] mode;
        logic [NGRP-1:0]        src;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_we && (32'(mode_idx) < NCELL)) begin
            cfg_d.mode[mode_idx] = mode_val;
        end
        if (src_we && (32'(src_grp) < NGRP)) begin
            cfg_d.src[src_grp] = src_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o = cfg_q.mode;
    assign src_o  = cfg_q.src;

    AST_MODE_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_o)); // R7
    AST_MODE_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && (32'(mode_idx) >= NCELL)) |=> $stable(mode_o)); // R7
    AST_SRC_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !src_we |=> $stable(src_o)); // R7
endmodule

// File: rtl/imc_group.sv
module imc_group
    import imc_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GW-1:0]         pin,
    input  cell_mode_e [GW-1:0]   mode,
    input  logic                  src,
    input  logic                  pt,
    input  logic                  strobe,
    output logic [GW-1:0]         out
);
    typedef struct packed {
        logic          prev;
        logic [GW-1:0] held;
    } grp_t;

    grp_t st_d, st_q;
    logic ctl;
    logic rise;

    assign ctl  = src ? strobe : pt;
    assign rise = ctl && !st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = ctl;
        out       = pin;
        for (int i = 0; i < GW; i++) begin
            case (mode[i])
                MODE_LATCH: begin
                    if (ctl) st_d.held[i] = pin[i];
                    out[i] = ctl ? pin[i] : st_q.held[i];
                end
                MODE_REG: begin
                    if (rise) st_d.held[i] = pin[i];
                    out[i] = st_q.held[i];
                end
                default: out[i] = pin[i];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < GW; i++) begin : g_chk
        AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] == MODE_REG && ctl && !st_q.prev) |=> st_q.held[i] == $past(pin[i])); // R4
        AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] == MODE_REG && !(ctl && !st_q.prev)) |=> $stable(st_q.held[i])); // R4
        AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] == MODE_LATCH && !ctl) |=> $stable(st_q.held[i])); // R3
    end
endmodule

// File: rtl/pin_capture_array.sv
module pin_capture_array
    import imc_pkg::*;
#(
    parameter int PW  = 8,
    parameter int PCW = 4,
    parameter int GW  = 4,
    localparam int NCELL  = 2*PW + PCW,
    localparam int NGRP   = NCELL / GW,
    localparam int IDX_W  = $clog2(NCELL),
    localparam int GIDX_W = $clog2(NGRP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     pin_a,
    input  logic [PW-1:0]     pin_b,
    input  logic [PCW-1:0]    pin_c,
    input  logic [NGRP-1:0]   pt_term,
    input  logic              addr_strobe,
    input  logic              mode_we,
    input  logic [IDX_W-1:0]  mode_idx,
    input  logic [1:0]        mode_val,
    input  logic              src_we,
    input  logic [GIDX_W-1:0] src_grp,
    input  logic              src_val,
    output logic [NCELL-1:0]  cell_bus,
    input  logic [1:0]        rd_sel,
    output logic [PW-1:0]     rd_data
);
    localparam int B_LO = PW;
    localparam int C_LO = 2*PW;

    logic [NCELL-1:0]       pins;
    cell_mode_e [NCELL-1:0] modes;
    logic [NGRP-1:0]        srcs;

    assign pins = {pin_c, pin_b, pin_a};

    imc_cfg #(
        .NCELL(NCELL), .NGRP(NGRP), .IDX_W(IDX_W), .GIDX_W(GIDX_W)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (mode_we),
        .mode_idx (mode_idx),
        .mode_val (cell_mode_e'(mode_val)),
        .src_we   (src_we),
        .src_grp  (src_grp),
        .src_val  (src_val),
        .mode_o   (modes),
        .src_o    (srcs)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        imc_group #(.GW(GW)) i_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pins[g*GW +: GW]),
            .mode   (modes[g*GW +: GW]),
            .src    (srcs[g]),
            .pt     (pt_term[g]),
            .strobe (addr_strobe),
            .out    (cell_bus[g*GW +: GW])
        );
    end

    always_comb begin
        case (rd_sel)
            2'b00:   rd_data = cell_bus[PW-1:0];
            2'b01:   rd_data = cell_bus[B_LO +: PW];
            2'b10:   rd_data = {{(PW-PCW){1'b0}}, cell_bus[C_LO +: PCW]};
            default: rd_data = '0;
        endcase
    end

    AST_RD_C_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'b10) |-> rd_data[PW-1:PCW] == '0); // R8
    AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'b11) |-> rd_data == '0); // R8
endmodule

// File: tb/test_pin_capture_array.sv
module test_pin_capture_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_a = '0, pin_b = '0;
    logic [3:0]  pin_c = '0;
    logic [4:0]  pt_term = '0;
    logic        addr_strobe = 1'b0;
    logic        mode_we = 1'b0;
    logic [4:0]  mode_idx = '0;
    logic [1:0]  mode_val = '0;
    logic        src_we = 1'b0;
    logic [2:0]  src_grp = '0;
    logic        src_val = 1'b0;
    logic [19:0] cell_bus;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_bus;
        logic [19:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    pin_capture_array i_pin_capture_array (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .pt_term(pt_term), .addr_strobe(addr_strobe),
        .mode_we(mode_we), .mode_idx(mode_idx), .mode_val(mode_val),
        .src_we(src_we), .src_grp(src_grp), .src_val(src_val),
        .cell_bus(cell_bus), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [19:0] act;
            it  = sb.pop_front();
            act = it.is_bus ? cell_bus : {12'h0, rd_data};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_rd(input logic [1:0] sel, input logic [7:0] exp, input string tag);
        rd_sel = sel;
        #1;
        sb.push_back('{is_bus: 1'b0, exp: {12'h0, exp}, tag: tag});
        step();
    endtask

    task automatic expect_bus(input logic [19:0] exp, input string tag);
        sb.push_back('{is_bus: 1'b1, exp: exp, tag: tag});
        step();
    endtask

    task automatic wr_mode(input int idx, input logic [1:0] val);
        mode_we = 1'b1; mode_idx = 5'(idx); mode_val = val;
        step();
        mode_we = 1'b0;
    endtask

    task automatic wr_src(input int grp, input logic val);
        src_we = 1'b1; src_grp = 3'(grp); src_val = val;
        step();
        src_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();

        // R1 R2: reset state is pass-through, pins visible at once
        pin_a = 8'hA5;
        expect_rd(2'b00, 8'hA5, "R1 reset pass-through port A");
        // R9: bus ordering
        pin_a = 8'h12; pin_b = 8'h34; pin_c = 4'h5;
        expect_bus(20'h53412, "R9 bus bit order");
        // R8: read mapping
        pin_c = 4'hF;
        expect_rd(2'b10, 8'h0F, "R8 port C upper nibble zero");
        expect_rd(2'b11, 8'h00, "R8 unused select reads zero");
        expect_rd(2'b01, 8'h34, "R8 port B read");

        // R3 R5: latch on group 0 (A cells 0..3) via pt_term[0]
        for (int k = 0; k < 4; k++) wr_mode(k, 2'b01);
        pin_a = 8'hFF;
        expect_rd(2'b00, 8'hF0, "R3 latch closed shows reset value");
        pt_term[0] = 1'b1;
        expect_rd(2'b00, 8'hFF, "R3 latch transparent");
        pin_a = 8'h3C;
        expect_rd(2'b00, 8'h3C, "R3 latch follows pin while open");
        pt_term[0] = 1'b0; pin_a = 8'h00;
        expect_rd(2'b00, 8'h0C, "R3 latch holds last sampled value");
        pt_term[1] = 1'b1; pin_a = 8'h05;
        expect_rd(2'b00, 8'h0C, "R5 other nibble term does not open latch");
        pt_term[1] = 1'b0;

        // R4 R6: register on group 2 (B cells 8..11) via strobe
        wr_src(2, 1'b1);
        for (int k = 8; k < 12; k++) wr_mode(k, 2'b10);
        pin_b = 8'h0A;
        expect_rd(2'b01, 8'h00, "R4 register holds reset value");
        addr_strobe = 1'b1;
        expect_rd(2'b01, 8'h00, "R4 no change before capturing edge");
        expect_rd(2'b01, 8'h0A, "R4 captures on strobe rise");
        pin_b = 8'h05;
        expect_rd(2'b01, 8'h0A, "R4 no capture while strobe stays high");
        addr_strobe = 1'b0;
        expect_rd(2'b01, 8'h0A, "R4 hold after strobe fall");
        pt_term[2] = 1'b1;
        expect_rd(2'b01, 8'h0A, "R6 unselected term ignored");
        expect_rd(2'b01, 8'h0A, "R6 unselected term ignored next edge");
        pt_term[2] = 1'b0;
        addr_strobe = 1'b1;
        step();
        expect_rd(2'b01, 8'h05, "R4 second strobe rise captures");

        // R5 R7: cell 19 latch, index 20 ignored
        wr_mode(19, 2'b01);
        pin_c = 4'hF;
        expect_rd(2'b10, 8'h07, "R5 cell 19 latch closed on pt_term[4]");
        wr_mode(20, 2'b01);
        pin_c = 4'h0;
        expect_rd(2'b10, 8'h00, "R7 index 20 write ignored");

        // R2: code 11 behaves as pass-through
        wr_mode(8, 2'b11);
        pin_b = 8'h00;
        expect_rd(2'b01, 8'h04, "R2 code 11 passes pin");

        pin_a = 8'h12; pin_c = 4'h5;
        expect_bus(20'h5041C, "R9 bus after mixed modes");

        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule